// File: doc/BRIEF.md
# Fiber transceiver collision, loopback and SQE controller

This block sits between the attachment-unit side and the optical side of a fiber Ethernet transceiver. It watches the transmit-active and receive-active indications, the two configuration straps (loopback disable and SQE enable) and the jabber and low-light status. From these it decides when a collision exists and drives the collision-indication pair (CI) with a gated oscillator. It also chooses what the data-in pair (DI) carries: the looped-back transmit data or the optical receive data. After every frame it produces a short SQE heartbeat on CI. It also drives the three stretched, retriggerable status LEDs for transmit, receive and collision.

The controller is a five-state machine. In ST_IDLE nothing is happening. In ST_XMIT a frame is being sent. ST_COLL means a collision has been declared. ST_SQE_WAIT is the post-frame delay, and ST_SQE_ON is the heartbeat itself. The transitions are as follows:
- IDLE, SQE_WAIT or SQE_ON go to XMIT on transmit-active, or to COLL when receive is also active and loopback is enabled.
- XMIT goes to COLL on receive overlap with loopback enabled.
- COLL goes back to XMIT when receive goes idle.
- XMIT or COLL go to SQE_WAIT when transmit ends with SQE allowed, and to IDLE when it is not allowed.
- SQE_WAIT goes to SQE_ON after the delay count.
- SQE_ON goes to IDLE after the length count.
- SQE_WAIT or SQE_ON go to IDLE when SQE becomes disallowed.

The oscillator toggles on every clock, so a 20 MHz clock gives a 10 MHz CI signal. Its enable is registered, so every CI pulse is a whole clock wide.

Top module: `fl_coll_ctrl`

## Requirements
- R1: With loopback enabled (lb_dis=0), transmit-active and receive-active both high at a clock edge declare a collision from the next cycle. The collision LED lights and the CI oscillator runs one cycle later.
- R2: With lb_dis=1 no collision is ever declared. DI carries rx_bit while rx_act is high and 0 otherwise, whatever the transmit side does.
- R3: A declared collision persists while both tx_act and rx_act stay high, even if lb_dis rises. It ends at the edge where either one is low, and a later overlap declares it again.
- R4: DI is selected as follows. In collision, DI is rx_bit. Otherwise, with tx_act=1 and lb_dis=0, DI is tx_bit and di_loop=1. Otherwise DI is rx_bit when rx_act=1, and 0 when it is not. di_loop is 0 outside the loopback case.
- R5: The oscillator enable is collision, the SQE heartbeat or jabber. The enable is registered. When it is on, ci_p toggles every clock starting at 1, and ci_n is its complement. When it is off, both ci_p and ci_n are 0. The two are never both 1.
- R6: jab=1 runs the oscillator from the next cycle, independently of transmit state.
- R7: When tx_act falls, the SQE heartbeat begins SQE_DLY cycles after the first clock edge that sees tx_act low. It lasts SQE_LEN cycles, during which the oscillator runs.
- R8: No SQE heartbeat is produced when sqe_en=0, low_light=1 or jab=1 at the end of the frame. Any of these conditions also cancels a pending or running heartbeat.
- R9: tx_act rising during the SQE delay or the heartbeat cancels that heartbeat and starts a new transmit.
- R10: xmt_led_n, rcv_led_n and col_led_n are active low. Each goes low the cycle after its event (tx_act, rx_act, declared collision) is seen and stays low for LED_HOLD cycles after the last edge at which the event was seen. A repeated event restarts the count.
- R11: jab_led_n equals the inverse of jab, and link_led_n equals low_light, with no stretching.
- R12: After reset, CI is idle (both 0), all stretched LEDs are off (1), no collision is declared and no heartbeat is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, nominally 20 MHz |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_act | input | 1 | Transmit data present on the DO pair (unsquelched) |
| rx_act | input | 1 | Optical receive data present (unsquelched) |
| lb_dis | input | 1 | Loopback-disable strap; 1 = full duplex, no collision |
| sqe_en | input | 1 | SQE heartbeat enable strap |
| jab | input | 1 | Jabber state from the jabber timer |
| low_light | input | 1 | Low-light (link fail) state |
| tx_bit | input | 1 | Transmit data bit from DO |
| rx_bit | input | 1 | Sliced optical receive data bit |
| ci_p | output | 1 | Collision pair, positive leg |
| ci_n | output | 1 | Collision pair, negative leg |
| di_bit | output | 1 | Data to the DI pair |
| di_loop | output | 1 | 1 when DI carries looped-back transmit data |
| xmt_led_n | output | 1 | Stretched transmit LED, active low |
| rcv_led_n | output | 1 | Stretched receive LED, active low |
| col_led_n | output | 1 | Stretched collision LED, active low |
| jab_led_n | output | 1 | Jabber LED, active low, unstretched |
| link_led_n | output | 1 | Link LED, low when light is sufficient |

## Verification
The hardest cases to reach from the ports are the races around the heartbeat. These are a new frame arriving in the middle of the SQE delay, and jabber or low light appearing after the heartbeat has been armed. The stimulus reaches them by ending a frame and then, a chosen number of cycles later, raising tx_act again or raising jab. The bench's behavioural model predicts the canceled heartbeat for each case. Collision persistence is exercised by dropping receive while transmit stays up, then overlapping again, and by raising lb_dis inside a collision.

// File: rtl/fl_coll_pkg.sv
package fl_coll_pkg;
    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_XMIT     = 3'd1,
        ST_COLL     = 3'd2,
        ST_SQE_WAIT = 3'd3,
        ST_SQE_ON   = 3'd4
    } link_st_t;
endpackage

// File: rtl/fl_coll_fsm.sv
module fl_coll_fsm
    import fl_coll_pkg::*;
#(
    parameter int SQE_DLY = 20,
    parameter int SQE_LEN = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_act,
    input  logic rx_act,
    input  logic lb_dis,
    input  logic sqe_ok,
    output logic col_on,
    output logic sqe_wait,
    output logic sqe_on
);
    localparam int MAXC  = (SQE_DLY > SQE_LEN) ? SQE_DLY : SQE_LEN;
    localparam int CNT_W = $clog2(MAXC + 1);
    localparam logic [CNT_W-1:0] DLY_LAST = CNT_W'(SQE_DLY - 1);
    localparam logic [CNT_W-1:0] LEN_LAST = CNT_W'(SQE_LEN - 1);

    link_st_t         state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             both_on;

    assign both_on = tx_act & rx_act & ~lb_dis;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE, ST_SQE_WAIT, ST_SQE_ON: begin
                if (tx_act) begin
                    state_d = both_on ? ST_COLL : ST_XMIT;
                    cnt_d   = '0;
                end else if (state_q != ST_IDLE && !sqe_ok) begin
                    state_d = ST_IDLE;
                    cnt_d   = '0;
                end else if (state_q == ST_SQE_WAIT) begin
                    if (cnt_q == DLY_LAST) begin
                        state_d = ST_SQE_ON;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end else if (state_q == ST_SQE_ON) begin
                    if (cnt_q == LEN_LAST) begin
                        state_d = ST_IDLE;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            ST_XMIT: begin
                if (!tx_act) begin
                    state_d = sqe_ok ? ST_SQE_WAIT : ST_IDLE;
                    cnt_d   = '0;
                end else if (both_on) begin
                    state_d = ST_COLL;
                end
            end
            ST_COLL: begin
                if (!tx_act) begin
                    state_d = sqe_ok ? ST_SQE_WAIT : ST_IDLE;
                    cnt_d   = '0;
                end else if (!rx_act) begin
                    state_d = ST_XMIT;
                end
            end
            default: begin
                state_d = ST_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    always_comb begin
        col_on   = (state_q == ST_COLL);
        sqe_wait = (state_q == ST_SQE_WAIT);
        sqe_on   = (state_q == ST_SQE_ON);
    end
endmodule

// File: rtl/fl_ci_osc.sv
module fl_ci_osc (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic ci_p,
    output logic ci_n
);
    logic en_q, osc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            osc_q <= 1'b0;
        end else begin
            en_q  <= en;
            osc_q <= en ? ~osc_q : 1'b0;
        end
    end

    assign ci_p = osc_q;
    assign ci_n = en_q & ~osc_q;
endmodule

// File: rtl/fl_led_stretch.sv
module fl_led_stretch #(
    parameter int LED_HOLD = 320000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic event_i,
    output logic led_n
);
    localparam int CW = $clog2(LED_HOLD + 1);
    localparam logic [CW-1:0] HOLD_V = CW'(LED_HOLD);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (event_i) begin
            cnt_q <= HOLD_V;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign led_n = (cnt_q == '0);
endmodule

// File: rtl/fl_coll_ctrl.sv
module fl_coll_ctrl #(
    parameter int SQE_DLY  = 20,
    parameter int SQE_LEN  = 20,
    parameter int LED_HOLD = 320000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_act,
    input  logic rx_act,
    input  logic lb_dis,
    input  logic sqe_en,
    input  logic jab,
    input  logic low_light,
    input  logic tx_bit,
    input  logic rx_bit,
    output logic ci_p,
    output logic ci_n,
    output logic di_bit,
    output logic di_loop,
    output logic xmt_led_n,
    output logic rcv_led_n,
    output logic col_led_n,
    output logic jab_led_n,
    output logic link_led_n
);
    localparam int NLED = 3;

    logic            col_on, sqe_wait, sqe_on;
    logic            sqe_ok, osc_en;
    logic [NLED-1:0] led_ev, led_out_n;

    assign sqe_ok = sqe_en & ~low_light & ~jab;
    assign osc_en = col_on | sqe_on | jab;

    fl_coll_fsm #(.SQE_DLY(SQE_DLY), .SQE_LEN(SQE_LEN)) fsm_i (
        .clk(clk), .rst_n(rst_n), .tx_act(tx_act), .rx_act(rx_act),
        .lb_dis(lb_dis), .sqe_ok(sqe_ok), .col_on(col_on),
        .sqe_wait(sqe_wait), .sqe_on(sqe_on)
    );

    fl_ci_osc osc_i (
        .clk(clk), .rst_n(rst_n), .en(osc_en), .ci_p(ci_p), .ci_n(ci_n)
    );

    assign led_ev = {col_on, rx_act, tx_act};

    for (genvar g = 0; g < NLED; g++) begin : g_led
        fl_led_stretch #(.LED_HOLD(LED_HOLD)) str_i (
            .clk(clk), .rst_n(rst_n), .event_i(led_ev[g]), .led_n(led_out_n[g])
        );
    end

    assign xmt_led_n = led_out_n[0];
    assign rcv_led_n = led_out_n[1];
    assign col_led_n = led_out_n[2];

    always_comb begin
        di_loop = ~col_on & tx_act & ~lb_dis;
        if (col_on)       di_bit = rx_bit;
        else if (di_loop) di_bit = tx_bit;
        else if (rx_act)  di_bit = rx_bit;
        else              di_bit = 1'b0;
    end

    assign jab_led_n  = ~jab;
    assign link_led_n = low_light;
endmodule

// File: rtl/fl_coll_ctrl_chk.sv
module fl_coll_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic tx_act,
    input logic rx_act,
    input logic lb_dis,
    input logic sqe_en,
    input logic low_light,
    input logic jab,
    input logic ci_p,
    input logic ci_n,
    input logic xmt_led_n,
    input logic col_on,
    input logic sqe_wait,
    input logic sqe_on,
    input logic osc_en
);
    // R5
    ci_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ci_p && ci_n));
    // R5
    ci_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (osc_en && !ci_p && !ci_n) |=> ci_p);
    // R2
    no_coll_strap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!col_on && lb_dis) |=> !col_on);
    // R3
    coll_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (col_on && tx_act && rx_act) |=> col_on);
    // R8
    sqe_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sqe_wait && !tx_act && (!sqe_en || low_light || jab)) |=> (!sqe_on && !sqe_wait));
    // R9
    sqe_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sqe_wait && tx_act) |=> (!sqe_wait && !sqe_on));
    // R10
    xmt_led_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_act |=> !xmt_led_n);
endmodule

bind fl_coll_ctrl fl_coll_ctrl_chk chk_i (
    .clk(clk), .rst_n(rst_n), .tx_act(tx_act), .rx_act(rx_act),
    .lb_dis(lb_dis), .sqe_en(sqe_en), .low_light(low_light), .jab(jab),
    .ci_p(ci_p), .ci_n(ci_n), .xmt_led_n(xmt_led_n), .col_on(col_on),
    .sqe_wait(sqe_wait), .sqe_on(sqe_on), .osc_en(osc_en)
);

// File: tb/fl_coll_ctrl_tb.sv
`timescale 1ns/1ps
module fl_coll_ctrl_tb_top;
    localparam int D    = 12;
    localparam int L    = 20;
    localparam int HOLD = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_act = 0, rx_act = 0, lb_dis = 0, sqe_en = 1, jab = 0, low_light = 0;
    logic tx_bit = 0, rx_bit = 0;
    logic ci_p, ci_n, di_bit, di_loop;
    logic xmt_led_n, rcv_led_n, col_led_n, jab_led_n, link_led_n;

    int checks = 0;
    int errors = 0;
    string tag = "R12";
    bit done = 0;

    always #2 clk = ~clk;

    fl_coll_ctrl #(.SQE_DLY(D), .SQE_LEN(L), .LED_HOLD(HOLD)) dut_i (
        .clk(clk), .rst_n(rst_n), .tx_act(tx_act), .rx_act(rx_act),
        .lb_dis(lb_dis), .sqe_en(sqe_en), .jab(jab), .low_light(low_light),
        .tx_bit(tx_bit), .rx_bit(rx_bit), .ci_p(ci_p), .ci_n(ci_n),
        .di_bit(di_bit), .di_loop(di_loop), .xmt_led_n(xmt_led_n),
        .rcv_led_n(rcv_led_n), .col_led_n(col_led_n), .jab_led_n(jab_led_n),
        .link_led_n(link_led_n)
    );

    // behavioural reference model
    bit m_coll, m_busy, m_osc, m_en;
    int m_sqe;
    int c_tx, c_rx, c_col;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_coll = 0; m_busy = 0; m_osc = 0; m_en = 0; m_sqe = -1;
            c_tx = 0; c_rx = 0; c_col = 0;
        end else begin
            bit ok, en;
            c_tx  = tx_act ? HOLD : (c_tx  > 0 ? c_tx  - 1 : 0);
            c_rx  = rx_act ? HOLD : (c_rx  > 0 ? c_rx  - 1 : 0);
            c_col = m_coll ? HOLD : (c_col > 0 ? c_col - 1 : 0);
            en = m_coll || (m_sqe >= D) || jab;
            m_en = en;
            m_osc = en ? !m_osc : 1'b0;
            ok = sqe_en && !low_light && !jab;
            if (tx_act) begin
                m_sqe = -1;
                m_coll = rx_act && (m_coll || !lb_dis);
            end else begin
                if (m_busy) m_sqe = ok ? 0 : -1;
                else if (m_sqe >= 0) begin
                    if (!ok) m_sqe = -1;
                    else begin
                        m_sqe++;
                        if (m_sqe == D + L) m_sqe = -1;
                    end
                end
                m_coll = 0;
            end
            m_busy = tx_act;
        end
    end

    task automatic chk(string what, string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s (%s) %s actual=%0b expected=%0b t=%0t", req, tag, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!done) begin
            logic e_di, e_loop;
            e_loop = !m_coll && tx_act && !lb_dis;
            e_di = m_coll ? rx_bit : e_loop ? tx_bit : rx_act ? rx_bit : 1'b0;
            chk("ci_p", "R5", ci_p, m_osc);
            chk("ci_n", "R5", ci_n, m_en && !m_osc);
            chk("di_bit", "R4", di_bit, e_di);
            chk("di_loop", "R4", di_loop, e_loop);
            chk("xmt_led_n", "R10", xmt_led_n, c_tx == 0);
            chk("rcv_led_n", "R10", rcv_led_n, c_rx == 0);
            chk("col_led_n", "R10", col_led_n, c_col == 0);
            chk("jab_led_n", "R11", jab_led_n, !jab);
            chk("link_led_n", "R11", link_led_n, low_light);
        end
    end

    task automatic run(int n);
        repeat (n) begin
            @(posedge clk); #1;
            tx_bit = 1'($urandom);
            rx_bit = 1'($urandom);
        end
    endtask

    task automatic frame(int n);
        tx_act = 1; run(n); tx_act = 0;
    endtask

    task automatic finish_run();
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        tag = "R12"; run(3); rst_n = 1; run(4);
        tag = "R7";  frame(30); run(50);
        tag = "R1";  tx_act = 1; run(5); rx_act = 1; run(15);
        tag = "R3";  lb_dis = 1; run(4); lb_dis = 0; rx_act = 0; run(5);
        rx_act = 1; run(5); tx_act = 0; run(10); rx_act = 0; run(50);
        tag = "R2";  lb_dis = 1; tx_act = 1; run(5); rx_act = 1; run(20);
        tx_act = 0; run(5); rx_act = 0; run(50); lb_dis = 0;
        tag = "R8";  sqe_en = 0; frame(10); run(50); sqe_en = 1;
        low_light = 1; frame(10); run(50); low_light = 0;
        frame(10); run(5); jab = 1; run(20); jab = 0; run(50);
        frame(10); run(D + 4); sqe_en = 0; run(10); sqe_en = 1; run(40);
        tag = "R9";  frame(10); run(6); frame(10); run(D + 3); frame(5); run(60);
        tag = "R10"; for (int i = 0; i < 8; i++) begin frame(3); run(20); end
        rx_act = 1; run(2); rx_act = 0; run(HOLD + 10);
        tag = "R6";  jab = 1; frame(30); run(10); jab = 0; run(50);
        finish_run();
    end

    initial begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog (%s) actual=timeout expected=finish", tag);
        finish_run();
    end
endmodule